// File: doc/BRIEF.md
# Timed I2C Byte Master

This block is a single-master I2C engine that the host drives one byte-level operation at a time. The operations are: open a transaction with a START, close it with a STOP, send a START followed by a 7-bit address byte, write a data byte, and read a data byte. The engine works the two bus lines as open-drain signals. It only pulls a line low through an output enable or lets it float, and it reads SDA back through a synchronizer.

Each bus phase has a fixed standard-mode length in whole microseconds. A prescaler turns the system clock into those microseconds, and its ratio is a parameter. The host offers a command while `busy` is low. It then waits for the one-cycle `done` pulse and reads `rd_data`, `ack_err` and `addr_rej`. Between commands the engine holds the lines where the last command left them, so the host can chain a transaction out of several commands. The engine does not support clock stretching or arbitration.

Top module: `i2cb_engine`

## Requirements
- R1: After reset both output enables are low, and `busy` and `done` are low. A command is taken when `cmd_valid` is high while `busy` is low. The codes are 1=START, 2=STOP, 3=ADDR, 4=WRITE and 5=READ; any other code is ignored and leaves `busy`, `done` and the bus untouched. `busy` is high from the cycle after acceptance until `done`, and `done` is a single-cycle pulse.
- R2: START first releases both lines for 5 µs, then pulls SDA low with SCL released for 4 µs, then pulls both lines low for 5 µs. `done` follows, and both lines stay low afterwards. Every phase lasts exactly its microsecond count times `CLKS_PER_US` clocks.
- R3: ADDR sends a START and then the byte formed from `cmd_data[6:0]` and `cmd_rw` (`cmd_rw`=1 for read) as bit 0. The byte is followed by the acknowledge slot and never by a STOP, even when `cmd_stop` is set.
- R4: Each written bit is placed on SDA with SCL low for 1 µs, then SCL is released for 4 µs, then pulled low for 5 µs. The bits go out MSB first, 8 per byte.
- R5: After a written byte, SDA is released and SCL stays low for 5 µs. SCL is then released for 4 µs and SDA is sampled at the end of that phase. A high level sets `ack_err`. SCL is then held low for 5 µs. `ack_err` and `addr_rej` clear when the next command is accepted.
- R6: STOP releases SCL with SDA low for 4 µs, then releases SDA. A WRITE with `cmd_stop` set ends with a STOP whether or not the byte was acknowledged.
- R7: An ADDR whose `cmd_data[6:3]` are all ones is rejected. `addr_rej` is set, `done` comes in the first cycle after acceptance, and neither line changes. Address 0x77 is accepted.
- R8: READ keeps SDA released. For each bit it releases SCL for 4 µs, samples SDA at the end of that phase, and then holds SCL low for 5 µs. The byte is assembled MSB first and is on `rd_data` at `done`.
- R9: After the 8 read bits the engine drives the acknowledge bit with the 1/4/5 µs bit timing. The bit is ACK (SDA low) when `cmd_last` is 0 and NACK (SDA released) when `cmd_last` is 1. SDA is then released and SCL held low for 5 µs more.
- R10: A READ ends with a STOP only when both `cmd_stop` and `cmd_last` are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd | input | 3 | Command code |
| cmd_data | input | 8 | Write byte, or 7-bit address in bits 6:0 |
| cmd_rw | input | 1 | Direction bit placed in the address byte |
| cmd_stop | input | 1 | Request a STOP after WRITE or READ |
| cmd_last | input | 1 | Last byte of a read (NACK it) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte received by the last READ |
| ack_err | output | 1 | Target did not acknowledge the written byte |
| addr_rej | output | 1 | Address rejected as reserved |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The bench builds the engine with `CLKS_PER_US` = 4 and the default standard-mode phase lengths. One microsecond is then four clocks, so a full address-plus-byte transaction takes a few hundred cycles. The exact cycle count of every command and phase width stays a small, hand-checkable number. A behavioural target on a pulled-up wired-AND bus acknowledges or refuses bytes and shifts read data out. This exercises both acknowledge outcomes, both read terminations and the reserved-address boundary.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_START = 3'd1,
    CMD_STOP  = 3'd2,
    CMD_ADDR  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_READ  = 3'd5
  } cmd_e;

  // bus phases of the sequencer
  typedef enum logic [4:0] {
    S_IDLE, S_BUF, S_HOLD, S_CLO,
    S_WSU, S_WHI, S_WLO,
    S_AREL, S_AHI, S_ALO,
    S_RHI, S_RLO,
    S_KSU, S_KHI, S_KLO, S_KREL,
    S_PSU, S_DONE
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2cb_timer.sv
module i2cb_timer #(
  parameter int CLKS_PER_US = 125,
  parameter int UW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [UW-1:0] dur_us,
  output logic          expire
);
  localparam int PW = $clog2(CLKS_PER_US + 1);
  localparam logic [PW-1:0] PRE_TOP = PW'(CLKS_PER_US - 1);

  logic          act_q, act_n;
  logic [PW-1:0] pre_q, pre_n;
  logic [UW-1:0] us_q, us_n;

  assign expire = act_q && (pre_q == '0) && (us_q == '0);

  always_comb begin
    act_n = act_q;
    pre_n = pre_q;
    us_n  = us_q;
    if (load) begin
      act_n = 1'b1;
      pre_n = PRE_TOP;
      us_n  = dur_us - UW'(1);
    end else if (act_q) begin
      if (pre_q == '0) begin
        if (us_q == '0) begin
          act_n = 1'b0;
        end else begin
          us_n  = us_q - UW'(1);
          pre_n = PRE_TOP;
        end
      end else begin
        pre_n = pre_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      act_q <= act_n;
      pre_q <= pre_n;
      us_q  <= us_n;
    end
  end

  // R2
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (dur_us != '0));

  // R2
  expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);

endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
#(
  parameter int UW      = 3,
  parameter int T_FREE  = 5,
  parameter int T_STHD  = 4,
  parameter int T_LOW   = 5,
  parameter int T_SETUP = 1,
  parameter int T_HIGH  = 4,
  parameter int T_SPSU  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [BYTE_W-1:0] din,
  input  logic              f_rw,
  input  logic              f_stop,
  input  logic              f_last,
  input  logic              sda_s,
  input  logic              tmr_expire,
  output logic              tmr_load,
  output logic [UW-1:0]     tmr_dur,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ack_err,
  output logic              addr_rej,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  phase_e            st, st_n;
  logic [BYTE_W-1:0] sh, sh_n, rd_q, rd_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic stop_q, stop_n, last_q, last_n, chain_q, chain_n;
  logic ack_q, ack_n, rej_q, rej_n, scl_q, scl_n, sda_q, sda_n;

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign rd_data  = rd_q;
  assign ack_err  = ack_q;
  assign addr_rej = rej_q;
  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;

  always_comb begin
    st_n = st; sh_n = sh; cnt_n = cnt; rd_n = rd_q;
    stop_n = stop_q; last_n = last_q; chain_n = chain_q;
    ack_n = ack_q; rej_n = rej_q;
    case (st)
      S_IDLE: if (cmd_valid) begin
        case (cmd_e'(cmd))
          CMD_START: begin
            st_n = S_BUF; chain_n = 1'b0; ack_n = 1'b0; rej_n = 1'b0;
          end
          CMD_STOP: begin
            st_n = S_PSU; ack_n = 1'b0; rej_n = 1'b0;
          end
          CMD_ADDR: begin
            ack_n = 1'b0;
            rej_n = 1'b0;
            if (din[6:3] == 4'hF) begin
              rej_n = 1'b1;
              st_n  = S_DONE;
            end else begin
              st_n = S_BUF; chain_n = 1'b1; stop_n = 1'b0;
              sh_n = {din[6:0], f_rw};
            end
          end
          CMD_WRITE: begin
            st_n = S_WSU; sh_n = din; stop_n = f_stop; cnt_n = '0;
            ack_n = 1'b0; rej_n = 1'b0;
          end
          CMD_READ: begin
            st_n = S_RHI; stop_n = f_stop; last_n = f_last; cnt_n = '0;
            ack_n = 1'b0; rej_n = 1'b0;
          end
          default: ;
        endcase
      end
      S_BUF:  if (tmr_expire) st_n = S_HOLD;
      S_HOLD: if (tmr_expire) st_n = S_CLO;
      S_CLO:  if (tmr_expire) begin
        st_n  = chain_q ? S_WSU : S_DONE;
        cnt_n = '0;
      end
      S_WSU:  if (tmr_expire) st_n = S_WHI;
      S_WHI:  if (tmr_expire) st_n = S_WLO;
      S_WLO:  if (tmr_expire) begin
        if (cnt == LAST_BIT) begin
          st_n = S_AREL;
        end else begin
          st_n  = S_WSU;
          cnt_n = cnt + CW'(1);
          sh_n  = {sh[BYTE_W-2:0], 1'b0};
        end
      end
      S_AREL: if (tmr_expire) st_n = S_AHI;
      S_AHI:  if (tmr_expire) begin
        ack_n = sda_s;
        st_n  = S_ALO;
      end
      S_ALO:  if (tmr_expire) st_n = stop_q ? S_PSU : S_DONE;
      S_RHI:  if (tmr_expire) begin
        sh_n = {sh[BYTE_W-2:0], sda_s};
        st_n = S_RLO;
      end
      S_RLO:  if (tmr_expire) begin
        st_n  = (cnt == LAST_BIT) ? S_KSU : S_RHI;
        cnt_n = cnt + CW'(1);
      end
      S_KSU:  if (tmr_expire) st_n = S_KHI;
      S_KHI:  if (tmr_expire) st_n = S_KLO;
      S_KLO:  if (tmr_expire) st_n = S_KREL;
      S_KREL: if (tmr_expire) begin
        rd_n = sh;
        st_n = (stop_q && last_q) ? S_PSU : S_DONE;
      end
      S_PSU:  if (tmr_expire) st_n = S_DONE;
      S_DONE: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  // line drive and timer load for the phase being entered
  always_comb begin
    scl_n    = scl_q;
    sda_n    = sda_q;
    tmr_load = 1'b0;
    tmr_dur  = UW'(T_LOW);
    if (st_n != st) begin
      tmr_load = 1'b1;
      case (st_n)
        S_BUF:  begin scl_n = 1'b0; sda_n = 1'b0; tmr_dur = UW'(T_FREE); end
        S_HOLD: begin scl_n = 1'b0; sda_n = 1'b1; tmr_dur = UW'(T_STHD); end
        S_CLO:  begin scl_n = 1'b1; sda_n = 1'b1; end
        S_WSU:  begin scl_n = 1'b1; sda_n = ~sh_n[BYTE_W-1]; tmr_dur = UW'(T_SETUP); end
        S_WHI:  begin scl_n = 1'b0; tmr_dur = UW'(T_HIGH); end
        S_WLO:  scl_n = 1'b1;
        S_AREL: begin scl_n = 1'b1; sda_n = 1'b0; end
        S_AHI:  begin scl_n = 1'b0; tmr_dur = UW'(T_HIGH); end
        S_ALO:  scl_n = 1'b1;
        S_RHI:  begin scl_n = 1'b0; sda_n = 1'b0; tmr_dur = UW'(T_HIGH); end
        S_RLO:  scl_n = 1'b1;
        S_KSU:  begin scl_n = 1'b1; sda_n = ~last_q; tmr_dur = UW'(T_SETUP); end
        S_KHI:  begin scl_n = 1'b0; tmr_dur = UW'(T_HIGH); end
        S_KLO:  scl_n = 1'b1;
        S_KREL: begin scl_n = 1'b1; sda_n = 1'b0; end
        S_PSU:  begin scl_n = 1'b0; sda_n = 1'b1; tmr_dur = UW'(T_SPSU); end
        S_DONE: begin
          tmr_load = 1'b0;
          if (st == S_PSU) begin scl_n = 1'b0; sda_n = 1'b0; end
        end
        default: tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; rd_q <= '0;
      stop_q <= 1'b0; last_q <= 1'b0; chain_q <= 1'b0;
      ack_q <= 1'b0; rej_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      st <= st_n; sh <= sh_n; cnt <= cnt_n; rd_q <= rd_n;
      stop_q <= stop_n; last_q <= last_n; chain_q <= chain_n;
      ack_q <= ack_n; rej_q <= rej_n; scl_q <= scl_n; sda_q <= sda_n;
    end
  end

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R4
  sda_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == S_HOLD || st == S_DONE));

  // R7
  rej_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && cmd == CMD_ADDR && din[6:3] == 4'hF)
      |=> (done && addr_rej && $stable(scl_oe) && $stable(sda_oe)));

  // R6
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PSU && tmr_expire) |=> (done && !scl_oe && !sda_oe));

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int CLKS_PER_US = 125,
  parameter int T_FREE      = 5,
  parameter int T_STHD      = 4,
  parameter int T_LOW       = 5,
  parameter int T_SETUP     = 1,
  parameter int T_HIGH      = 4,
  parameter int T_SPSU      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd,
  input  logic [7:0]  cmd_data,
  input  logic        cmd_rw,
  input  logic        cmd_stop,
  input  logic        cmd_last,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rd_data,
  output logic        ack_err,
  output logic        addr_rej,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int MAX_US = imax(imax(imax(T_FREE, T_STHD), imax(T_LOW, T_SETUP)),
                               imax(T_HIGH, T_SPSU));
  localparam int UW = $clog2(MAX_US + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   tmr_load, tmr_expire;
  logic [UW-1:0]          tmr_dur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sda_in};
  end

  i2cb_timer #(.CLKS_PER_US(CLKS_PER_US), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .dur_us(tmr_dur),
    .expire(tmr_expire)
  );

  i2cb_seq #(
    .UW(UW), .T_FREE(T_FREE), .T_STHD(T_STHD), .T_LOW(T_LOW),
    .T_SETUP(T_SETUP), .T_HIGH(T_HIGH), .T_SPSU(T_SPSU)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .din(cmd_data), .f_rw(cmd_rw), .f_stop(cmd_stop), .f_last(cmd_last),
    .sda_s(sync_q[SYNC_STAGES-1]), .tmr_expire(tmr_expire),
    .tmr_load(tmr_load), .tmr_dur(tmr_dur), .busy(busy), .done(done),
    .rd_data(rd_data), .ack_err(ack_err), .addr_rej(addr_rej),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

endmodule

// File: tb/i2cb_engine_tb.sv
module i2cb_engine_tb;
  localparam int C = 4;
  localparam int US_START = 5 + 4 + 5;
  localparam int US_WBYTE = 8 * (1 + 4 + 5) + (5 + 4 + 5);
  localparam int US_RBYTE = 8 * (4 + 5) + (1 + 4 + 5 + 5);
  localparam int US_STOP  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_rw, cmd_stop, cmd_last;
  logic [2:0] cmd;
  logic [7:0] cmd_data, rd_data;
  logic       busy, done, ack_err, addr_rej, scl_oe, sda_oe;
  logic       tgt_sda = 1'b0;
  wire        scl_bus = ~scl_oe;
  wire        sda_bus = ~(sda_oe | tgt_sda);

  i2cb_engine #(.CLKS_PER_US(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .cmd_data(cmd_data), .cmd_rw(cmd_rw), .cmd_stop(cmd_stop),
    .cmd_last(cmd_last), .busy(busy), .done(done), .rd_data(rd_data),
    .ack_err(ack_err), .addr_rej(addr_rej), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target model on the wired-AND bus
  int nb = 0, starts = 0, stops = 0, sda_edges = 0;
  int scl_rise = 0, scl_fall = 0, sda_fall = 0, high_w = 0;
  logic tx_mode = 1'b0, ack_en = 1'b1, mack = 1'b0;
  logic [7:0] rx = 8'h00, tx = 8'h00;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    if (p_scl && scl_bus && p_sda && !sda_bus) begin starts++; nb = -1; end
    if (p_scl && scl_bus && !p_sda && sda_bus) stops++;
    if (p_sda != sda_bus) sda_edges++;
    if (p_sda && !sda_bus) sda_fall = cyc;
    if (!p_scl && scl_bus) begin
      scl_rise = cyc;
      if (!tx_mode && nb >= 0 && nb < 8) rx = {rx[6:0], sda_bus};
      if (tx_mode && nb == 8) mack = sda_bus;
    end
    if (p_scl && !scl_bus) begin
      scl_fall = cyc;
      high_w = cyc - scl_rise;
      nb++;
      if (!tx_mode) begin
        if (nb == 8) tgt_sda = ack_en;
        else if (nb == 9) tgt_sda = 1'b0;
      end else begin
        if (nb >= 0 && nb < 8) tgt_sda = ~tx[7-nb];
        else tgt_sda = 1'b0;
      end
    end
    p_scl = scl_bus;
    p_sda = sda_bus;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int lat, acc_cyc;
  logic busy_at;

  task automatic run_cmd(input logic [2:0] c, input logic [7:0] d,
                         input logic rw, input logic sp, input logic la);
    @(negedge clk);
    cmd = c; cmd_data = d; cmd_rw = rw; cmd_stop = sp; cmd_last = la;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    acc_cyc = cyc;
    busy_at = busy;
    while (!done && (cyc - acc_cyc) < 5000) @(negedge clk);
    lat = cyc - acc_cyc;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
  endtask

  task automatic t_ignore();
    int e0, seen;
    e0 = sda_edges; seen = 0;
    @(negedge clk); cmd = 3'd6; cmd_valid = 1'b1;
    @(negedge clk); cmd = 3'd0;
    @(negedge clk); cmd_valid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (busy || done) seen = 1;
      @(negedge clk);
    end
    chk("R1 unknown code ignored", seen, 0);
    chk("R1 unknown code bus quiet", sda_edges - e0, 0);
  endtask

  task automatic t_start();
    int s0;
    s0 = starts;
    run_cmd(3'd1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R1 busy after accept", busy_at, 1);
    chk("R2 start latency", lat, US_START * C);
    chk("R2 bus free time", sda_fall - acc_cyc, 5 * C);
    chk("R2 start hold", scl_fall - sda_fall, 4 * C);
    chk("R2 start seen", starts - s0, 1);
    chk("R2 lines held low", {scl_bus, sda_bus}, 0);
  endtask

  task automatic t_stop();
    int p0;
    p0 = stops;
    run_cmd(3'd2, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R6 stop latency", lat, US_STOP * C);
    chk("R6 stop seen", stops - p0, 1);
    chk("R6 lines released", {scl_bus, sda_bus}, 3);
  endtask

  task automatic t_addr_write();
    int p0;
    p0 = stops; tx_mode = 1'b0; ack_en = 1'b1; rx = 8'h00;
    run_cmd(3'd3, 8'h50, 1'b0, 1'b1, 1'b0);
    chk("R3 address byte", rx, 8'hA0);
    chk("R3 no stop after address", stops - p0, 0);
    chk("R3 address latency", lat, (US_START + US_WBYTE) * C);
    chk("R5 address acked", ack_err, 0);
  endtask

  task automatic t_write_ack();
    nb = 0; rx = 8'h00; ack_en = 1'b1;
    run_cmd(3'd4, 8'h3C, 1'b0, 1'b0, 1'b0);
    chk("R4 write data msb first", rx, 8'h3C);
    chk("R4 write latency", lat, US_WBYTE * C);
    chk("R4 scl high width", high_w, 4 * C);
    chk("R5 ack ok", ack_err, 0);
  endtask

  task automatic t_write_nack_stop();
    int p0;
    p0 = stops; nb = 0; rx = 8'h00; ack_en = 1'b0;
    run_cmd(3'd4, 8'hC5, 1'b0, 1'b1, 1'b0);
    chk("R4 write data", rx, 8'hC5);
    chk("R5 nack flagged", ack_err, 1);
    chk("R6 stop after nacked write", stops - p0, 1);
    chk("R6 write+stop latency", lat, (US_WBYTE + US_STOP) * C);
  endtask

  task automatic t_reject();
    int e0, s0;
    e0 = sda_edges; s0 = starts;
    run_cmd(3'd3, 8'h7A, 1'b0, 1'b0, 1'b0);
    chk("R7 reject flag", addr_rej, 1);
    chk("R7 reject latency", lat, 0);
    chk("R7 reject bus quiet", sda_edges - e0, 0);
    chk("R5 ack_err cleared on accept", ack_err, 0);
    tx_mode = 1'b0; ack_en = 1'b1; rx = 8'h00;
    run_cmd(3'd3, 8'h77, 1'b1, 1'b0, 1'b0);
    chk("R7 boundary 0x77 accepted", addr_rej, 0);
    chk("R3 read address byte", rx, 8'hEF);
    chk("R3 start before address", starts - s0, 1);
  endtask

  task automatic t_read(input logic [7:0] val, input logic la, input logic sp,
                        input int exp_stops, input int exp_lat);
    int p0;
    p0 = stops; tx_mode = 1'b1; tx = val; nb = 0; tgt_sda = ~val[7];
    run_cmd(3'd5, 8'h00, 1'b0, sp, la);
    chk("R8 read data", rd_data, val);
    chk("R9 master ack level", mack, la);
    chk("R10 stop after read", stops - p0, exp_stops);
    chk("R8 read latency", lat, exp_lat);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = 3'd0; cmd_data = 8'h00;
    cmd_rw = 1'b0; cmd_stop = 1'b0; cmd_last = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_ignore();
    t_start();
    t_stop();
    t_addr_write();
    t_write_ack();
    t_write_nack_stop();
    t_reject();
    t_read(8'hA5, 1'b0, 1'b1, 0, US_RBYTE * C);
    t_read(8'h5A, 1'b1, 1'b0, 0, US_RBYTE * C);
    t_read(8'h96, 1'b1, 1'b1, 1, (US_RBYTE + US_STOP) * C);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule